// File: doc/BRIEF.md
# Dual-Lane Synchronous Serial Receiver

This block is a receive-only serial slave for a radio tuner that streams sample words over a serial clock, a frame-sync line and two data lines. The external master drives all of these lines. The block drives nothing back on the serial side. The block holds two capture lanes that share the incoming clock and sync. Lane 0 shifts in data line 0 and lane 1 shifts in data line 1. Each lane has its own enable, its own parallel word output, its own one-cycle valid strobe and its own framing-error pulse.

The serial lines are brought into the system clock domain through two-flop synchronisers, and their transitions are found by edge detection. A shared configuration register, written through a write strobe, selects two settings for both lanes: which sync transition opens a frame, and how many bits make up a word. With both lanes enabled they start from the same sync event and run in lockstep. With one lane enabled, the other lane's data line has no effect, so either lane can serve as a single-line receiver.

Top module: `dual_lane_rx`

## Requirements
- R1: After reset every word output is zero and every valid and framing-error output is low.
- R2: Out of reset the configuration is sync active-high (polarity bit 1) and a word length of 32 bits, and it applies until the first configuration write.
- R3: Data is sampled on each rising serial clock, MSB first. After the configured number of bits, the lane presents the word right-aligned, with the upper bits zero, together with exactly one single-cycle valid pulse. The word output changes only together with that pulse.
- R4: With polarity bit 1, a low-to-high sync transition opens a frame. With polarity bit 0, a high-to-low transition opens a frame, and a low-to-high transition opens nothing.
- R5: A configuration write clamps a requested length below 8 to 8 and a length above 32 to 32.
- R6: Lane 0 captures data line 0 and lane 1 captures data line 1, both from the same opening sync transition, and each lane delivers its own word.
- R7: When only lane 1 is enabled, data line 0 has no effect. Lane 0 raises no valid or error pulse, and its word output keeps its value.
- R8: A frame-opening sync transition that arrives while a word is partly shifted in discards the partial bits, gives one framing-error pulse on that lane and restarts capture. The word that follows is delivered intact.
- R9: A disabled lane never asserts valid or framing error. A lane enabled in the middle of a frame captures nothing until the next frame-opening sync transition.
- R10: Once a word completes, the lane ignores further serial clocks until the next frame-opening sync transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| sync_i | input | 1 | Frame sync from the master (asynchronous) |
| d0_i | input | 1 | Serial data line for lane 0 |
| d1_i | input | 1 | Serial data line for lane 1 |
| en0_i | input | 1 | Lane 0 enable |
| en1_i | input | 1 | Lane 1 enable |
| cfg_wr_i | input | 1 | Loads the configuration register |
| cfg_pol_i | input | 1 | Sync polarity: 1 = rising edge opens a frame, 0 = falling edge |
| cfg_len_i | input | LEN_W | Requested word length in bits |
| word0_o | output | MAX_W | Lane 0 received word |
| valid0_o | output | 1 | Lane 0 word strobe |
| ferr0_o | output | 1 | Lane 0 framing-error pulse |
| word1_o | output | MAX_W | Lane 1 received word |
| valid1_o | output | 1 | Lane 1 word strobe |
| ferr1_o | output | 1 | Lane 1 framing-error pulse |

## Verification
The bench builds the block with its defaults: MAX_W of 32 and a 6-bit length field. With these values every legal length from 8 to 32 can be reached, and so can requests of 3 and 40 that exercise the clamp on both sides. Random frames mix lengths, polarities and data on both lanes. Directed cases add a truncated frame, a lane enabled mid-frame and clocks sent after a finished word.

// File: rtl/drx_pkg.sv
package drx_pkg;
    localparam int unsigned DRX_LANES = 2;
    localparam int unsigned DRX_MIN_W = 8;

    typedef enum logic {
        SYNC_FALL_OPENS = 1'b0,
        SYNC_RISE_OPENS = 1'b1
    } sync_pol_e;
endpackage

// File: rtl/drx_sync.sv
module drx_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_o = sy_q.s2;
endmodule

// File: rtl/drx_lane.sv
module drx_lane #(
    parameter  int MAX_W = 32,
    localparam int CW    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             bit_stb_i,
    input  logic             bit_i,
    input  logic [CW-1:0]    len_i,
    output logic [MAX_W-1:0] word_o,
    output logic             valid_o,
    output logic             ferr_o
);
    typedef struct packed {
        logic             armed;
        logic [CW-1:0]    cnt;
        logic [MAX_W-1:0] sh;
        logic [MAX_W-1:0] word;
        logic             valid;
        logic             ferr;
    } ln_t;

    ln_t ln_d, ln_q;

    always_comb begin
        ln_d       = ln_q;
        ln_d.valid = 1'b0;
        ln_d.ferr  = 1'b0;
        if (!en_i) begin
            ln_d.armed = 1'b0;
            ln_d.cnt   = '0;
            ln_d.sh    = '0;
        end else begin
            if (start_i) begin
                // a new frame while bits are pending throws them away
                ln_d.ferr  = ln_q.armed && (ln_q.cnt != '0);
                ln_d.armed = 1'b1;
                ln_d.cnt   = '0;
                ln_d.sh    = '0;
            end
            if (ln_d.armed && bit_stb_i) begin
                ln_d.sh  = {ln_d.sh[MAX_W-2:0], bit_i};
                ln_d.cnt = ln_d.cnt + CW'(1);
                if (ln_d.cnt == len_i) begin
                    ln_d.word  = ln_d.sh;
                    ln_d.valid = 1'b1;
                    ln_d.armed = 1'b0;
                    ln_d.cnt   = '0;
                    ln_d.sh    = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign word_o  = ln_q.word;
    assign valid_o = ln_q.valid;
    assign ferr_o  = ln_q.ferr;
endmodule

// File: rtl/dual_lane_rx.sv
module dual_lane_rx
    import drx_pkg::*;
#(
    parameter  int MAX_W = 32,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_i,
    input  logic             sync_i,
    input  logic             d0_i,
    input  logic             d1_i,
    input  logic             en0_i,
    input  logic             en1_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_pol_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    output logic [MAX_W-1:0] word0_o,
    output logic             valid0_o,
    output logic             ferr0_o,
    output logic [MAX_W-1:0] word1_o,
    output logic             valid1_o,
    output logic             ferr1_o
);
    localparam int SYN_N = 2 + DRX_LANES;
    localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(DRX_MIN_W);
    localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_W);

    typedef struct packed {
        sync_pol_e        pol;
        logic [LEN_W-1:0] len;
        logic             sck_prev;
        logic             sync_prev;
    } top_t;

    top_t top_d, top_q;

    logic [SYN_N-1:0]     syn;
    logic                 sck_s, sync_s;
    logic                 bit_stb, start;
    logic [DRX_LANES-1:0] lane_en, lane_bit, lane_valid, lane_ferr;
    logic [MAX_W-1:0]     lane_word [DRX_LANES];

    drx_sync #(.N(SYN_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({sck_i, sync_i, d1_i, d0_i}),
        .sync_o (syn)
    );

    assign sck_s    = syn[3];
    assign sync_s   = syn[2];
    assign lane_bit = syn[1:0];
    assign lane_en  = {en1_i, en0_i};

    assign bit_stb = sck_s & ~top_q.sck_prev;
    assign start   = (top_q.pol == SYNC_RISE_OPENS) ? (sync_s & ~top_q.sync_prev)
                                                    : (~sync_s & top_q.sync_prev);

    always_comb begin
        top_d           = top_q;
        top_d.sck_prev  = sck_s;
        top_d.sync_prev = sync_s;
        if (cfg_wr_i) begin
            top_d.pol = sync_pol_e'(cfg_pol_i);
            if (cfg_len_i < LEN_LO)      top_d.len = LEN_LO;
            else if (cfg_len_i > LEN_HI) top_d.len = LEN_HI;
            else                         top_d.len = cfg_len_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.pol       <= SYNC_RISE_OPENS;
            top_q.len       <= LEN_HI;
            top_q.sck_prev  <= 1'b0;
            top_q.sync_prev <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar g = 0; g < DRX_LANES; g++) begin : g_lane
        drx_lane #(.MAX_W(MAX_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (lane_en[g]),
            .start_i  (start),
            .bit_stb_i(bit_stb),
            .bit_i    (lane_bit[g]),
            .len_i    (top_q.len),
            .word_o   (lane_word[g]),
            .valid_o  (lane_valid[g]),
            .ferr_o   (lane_ferr[g])
        );
    end

    assign word0_o  = lane_word[0];
    assign word1_o  = lane_word[1];
    assign valid0_o = lane_valid[0];
    assign valid1_o = lane_valid[1];
    assign ferr0_o  = lane_ferr[0];
    assign ferr1_o  = lane_ferr[1];
endmodule

// File: rtl/drx_chk.sv
module drx_chk #(
    parameter int MAX_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en0_i,
    input logic             en1_i,
    input logic [MAX_W-1:0] word0_o,
    input logic             valid0_o,
    input logic             ferr0_o,
    input logic [MAX_W-1:0] word1_o,
    input logic             valid1_o,
    input logic             ferr1_o
);
    // R3
    single_pulse0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid0_o |=> !valid0_o);
    // R3
    single_pulse1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid1_o |=> !valid1_o);
    // R3
    word0_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word0_o != $past(word0_o)) |-> valid0_o);
    // R3
    word1_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word1_o != $past(word1_o)) |-> valid1_o);
    // R9
    idle0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en0_i |=> !(valid0_o || ferr0_o));
    // R9
    idle1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en1_i |=> !(valid1_o || ferr1_o));
    // R8
    ferr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((ferr0_o && valid0_o) || (ferr1_o && valid1_o)));
endmodule

bind dual_lane_rx drx_chk #(.MAX_W(MAX_W)) u_drx_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en0_i   (en0_i),
    .en1_i   (en1_i),
    .word0_o (word0_o),
    .valid0_o(valid0_o),
    .ferr0_o (ferr0_o),
    .word1_o (word1_o),
    .valid1_o(valid1_o),
    .ferr1_o (ferr1_o)
);

// File: tb/dual_lane_rx_test.sv
module dual_lane_rx_test;
    localparam int MAX_W = 32;
    localparam int LEN_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sync = 1'b0, d0 = 1'b0, d1 = 1'b0;
    logic en0 = 1'b0, en1 = 1'b0;
    logic cfg_wr = 1'b0, cfg_pol = 1'b1;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [MAX_W-1:0] word0, word1;
    logic valid0, valid1, ferr0, ferr1;

    int n_chk = 0, n_fail = 0;
    int v0 = 0, v1 = 0, f0 = 0, f1 = 0;
    logic [31:0] last0 = '0, last1 = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_lane_rx #(.MAX_W(MAX_W)) uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sync_i(sync),
        .d0_i(d0), .d1_i(d1), .en0_i(en0), .en1_i(en1),
        .cfg_wr_i(cfg_wr), .cfg_pol_i(cfg_pol), .cfg_len_i(cfg_len),
        .word0_o(word0), .valid0_o(valid0), .ferr0_o(ferr0),
        .word1_o(word1), .valid1_o(valid1), .ferr1_o(ferr1)
    );

    always @(negedge clk) begin
        if (valid0) begin v0++; last0 = word0; end
        if (valid1) begin v1++; last1 = word1; end
        if (ferr0) f0++;
        if (ferr1) f1++;
    end

    function automatic logic [31:0] mask_w(logic [31:0] w, int len);
        logic [63:0] m;
        m = (64'd1 << len) - 64'd1;
        return w & m[31:0];
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(logic pol, int len);
        cfg_pol = pol; cfg_len = LEN_W'(len); cfg_wr = 1'b1;
        tick(1);
        cfg_wr = 1'b0;
        tick(1);
    endtask

    task automatic open_frame(logic pol);
        sync = ~pol; tick(6);
        sync = pol;  tick(6);
    endtask

    task automatic shift_bits(int n, logic [31:0] w0, logic [31:0] w1);
        for (int i = n - 1; i >= 0; i--) begin
            d0 = w0[i]; d1 = w1[i];
            tick(3); sck = 1'b1;
            tick(3); sck = 1'b0;
        end
        tick(8);
    endtask

    task automatic frame_chk(string tag, logic pol, int len, logic [31:0] w0, logic [31:0] w1);
        int b0, b1;
        b0 = v0; b1 = v1;
        open_frame(pol);
        shift_bits(len, w0, w1);
        chk(v0 == b0 + 1, {tag, " lane0 count"}, 32'(v0 - b0), 32'd1);
        chk(last0 == mask_w(w0, len), {tag, " lane0 word"}, last0, mask_w(w0, len));
        chk(v1 == b1 + 1, {tag, " lane1 count"}, 32'(v1 - b1), 32'd1);
        chk(last1 == mask_w(w1, len), {tag, " lane1 word"}, last1, mask_w(w1, len));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int b0, b1, len;
        logic [31:0] w0, w1, keep0;
        void'($urandom(32'd2024));
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R1 reset state
        chk(word0 == '0 && word1 == '0, "R1 words", word0 ^ word1, 32'd0);
        chk(!valid0 && !valid1 && !ferr0 && !ferr1, "R1 strobes",
            {28'd0, valid0, valid1, ferr0, ferr1}, 32'd0);

        en0 = 1'b1; en1 = 1'b1;
        // R2 default rising sync, 32-bit word
        frame_chk("R2 default cfg", 1'b1, 32, 32'hC0FFEE11, 32'h8BADF00D);

        // R3 MSB first, 8-bit right aligned
        set_cfg(1'b1, 8);
        frame_chk("R3 len8", 1'b1, 8, 32'h000000A5, 32'h0000003C);

        // R10 clocks after a finished word are ignored
        b0 = v0; b1 = v1;
        shift_bits(8, 32'hFF, 32'hFF);
        chk(v0 == b0 && v1 == b1, "R10 no word without sync", 32'(v0 - b0 + v1 - b1), 32'd0);

        // R5 clamp low and high
        set_cfg(1'b1, 3);
        frame_chk("R5 clamp to 8", 1'b1, 8, 32'h0000005A, 32'h000000C3);
        set_cfg(1'b1, 40);
        frame_chk("R5 clamp to 32", 1'b1, 32, 32'h12345678, 32'hFEDCBA98);

        // R4 falling sync opens a frame when polarity is 0
        set_cfg(1'b0, 12);
        frame_chk("R4 falling opens", 1'b0, 12, 32'h00000ABC, 32'h00000123);
        b0 = v0; b1 = v1;
        sync = 1'b0; tick(6); sync = 1'b1; tick(6);
        shift_bits(12, 32'hFFF, 32'hFFF);
        chk(v0 == b0 && v1 == b1, "R4 rising ignored", 32'(v0 - b0 + v1 - b1), 32'd0);

        // R8 truncated frame
        set_cfg(1'b1, 8);
        open_frame(1'b1);
        shift_bits(5, 32'h1F, 32'h15);
        b0 = v0; b1 = v1;
        open_frame(1'b1);
        chk(f0 == 1 && f1 == 1, "R8 ferr pulse", 32'(f0 * 16 + f1), 32'h11);
        chk(v0 == b0 && v1 == b1, "R8 no partial word", 32'(v0 - b0 + v1 - b1), 32'd0);
        shift_bits(8, 32'h96, 32'h69);
        chk(last0 == 32'h96 && last1 == 32'h69, "R8 next word intact",
            last0 ^ last1, 32'h96 ^ 32'h69);

        // R7 lane 1 alone, D0 toggling
        en0 = 1'b0;
        keep0 = word0;
        b0 = v0; b1 = v1;
        open_frame(1'b1);
        shift_bits(8, 32'hAA, 32'h4D);
        chk(v0 == b0 && f0 == 1, "R7 lane0 silent", 32'(v0 - b0), 32'd0);
        chk(word0 == keep0, "R7 lane0 word held", word0, keep0);
        chk(v1 == b1 + 1 && last1 == 32'h4D, "R7 lane1 word", last1, 32'h4D);

        // R9 enable mid-frame waits for next sync
        b0 = v0; b1 = v1;
        open_frame(1'b1);
        shift_bits(3, 32'hE7 >> 5, 32'h71 >> 5);
        en0 = 1'b1;
        shift_bits(5, 32'hE7, 32'h71);
        chk(v0 == b0, "R9 mid-frame enable waits", 32'(v0 - b0), 32'd0);
        chk(v1 == b1 + 1 && last1 == 32'h71, "R9 lane1 unaffected", last1, 32'h71);
        frame_chk("R9 next frame captured", 1'b1, 8, 32'hE7, 32'h71);

        // R6 random frames on both lanes
        for (int k = 0; k < 25; k++) begin
            logic pol;
            len = 8 + int'($urandom_range(24));
            pol = 1'($urandom_range(1));
            w0 = $urandom; w1 = $urandom;
            set_cfg(pol, len);
            frame_chk("R6 random", pol, len, w0, w1);
        end
        chk(f0 == 1 && f1 == 1, "R8 no spurious ferr", 32'(f0 + f1), 32'd2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule